// File: doc/BRIEF.md
# Oversampled Manchester Bit Decoder

This block turns the one-bit carrier-present output of an envelope slicer into Manchester data bits. It runs on a clock at 32 times the bit rate, which is about 3.906 kbit/s nominally, so one bit lasts 32 clock ticks. In every bit the carrier fills exactly one half, and the value of the bit is carried by the direction of the transition at the middle of the bit.

The slicer signal first passes through a two-stage synchronizer. While searching, the decoder measures the spacing between successive transitions. Two transitions about one bit apart can only be two mid-bit transitions, so the decoder takes bit alignment from them. A valid Manchester preamble that alternates its bit values produces such a pair. Once locked, the decoder expects each mid-bit transition inside a window of plus or minus four ticks around tick 16. It re-centres its tick counter on every transition it accepts, and it ignores transitions near the bit boundaries. An input that selects polarity swaps which edge direction stands for a one.

Each decoded bit appears with a one-cycle strobe. If the expected mid-bit transition does not arrive, the decoder reports a one-cycle error pulse, drops its locked flag and goes back to searching.

Top module: `manchester_rx`

## Requirements
- R1: The slicer input passes two synchronizer flops and one edge register. A transition that is first sampled at clock edge k yields its bit strobe registered at edge k+2.
- R2: While searching, a transition that comes 28 to 36 ticks after the previous transition establishes lock. The locked flag rises together with the strobe of the bit that this transition ends.
- R3: With `pol_invert` low, a rising mid-bit transition (no carrier in the first half) decodes as 1, and a falling one (carrier in the first half) decodes as 0.
- R4: With `pol_invert` high, the mapping is inverted: a rising mid-bit transition decodes as 0 and a falling one as 1.
- R5: While locked, the first transition that arrives between ticks 12 and 20 of a bit is accepted as that bit's mid-bit edge. The tick counter is re-centred so that this edge counts as tick 16. Mid-bit edges that drift by up to 4 ticks from bit to bit therefore decode without error.
- R6: While locked, transitions outside the window, and any further transition inside the window after one has been accepted, produce no strobe. Boundary transitions between two equal bits are among them.
- R7: If tick 20 passes while locked and no edge has been accepted, `decode_err` pulses for exactly one cycle, `locked` falls in the same cycle, and no strobe is issued.
- R8: During and right after reset, `bit_valid`, `bit_data`, `locked` and `decode_err` are all low.
- R9: A stream of equal Manchester bits, whose transitions are 16 ticks apart, and an idle line never cause lock or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 32 ticks per bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slicer_in | input | 1 | Carrier-present level from the slicer (1 = carrier) |
| pol_invert | input | 1 | 0: rising mid-bit edge is 1; 1: rising mid-bit edge is 0 |
| bit_data | output | 1 | Last decoded bit value, valid while `bit_valid` is high |
| bit_valid | output | 1 | One-cycle strobe per decoded bit |
| locked | output | 1 | High while bit alignment is held |
| decode_err | output | 1 | One-cycle pulse when an expected mid-bit edge is missing |

## Verification
The assertions assume that `pol_invert` changes only while the decoder is searching. They also assume that the slicer input holds each level for at least a few ticks, so that the synchronized level reflects the driven waveform one level per transition. The stimulus changes the input only at negative clock edges, in whole-tick runs of at least 9 ticks, and changes polarity only between messages separated by idle time. Bit patterns include alternating preambles, runs of equal bits, mid-bit edges that drift by up to 4 ticks, an edge pushed 7 ticks late, and long idle gaps after each message, so that the missing-edge error is reached.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic {
    TRK_SEARCH = 1'b0,
    TRK_LOCK   = 1'b1
  } trk_state_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // warm-up counter for the latency check below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  a_r1_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (level == $past(din, STAGES)));
endmodule

// File: rtl/mrx_phase_track.sv
module mrx_phase_track
  import mrx_pkg::*;
#(
  parameter int OSR     = 32,
  parameter int WIN     = 4,
  parameter int ACQ_TOL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic mid_hit,
  output logic lost,
  output logic locked
);
  localparam int CW = $clog2(OSR);
  localparam int GW = $clog2(2 * OSR) + 1;
  localparam logic [CW-1:0] TICK_LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] TICK_AFTER = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] WIN_LO     = CW'(OSR / 2 - WIN);
  localparam logic [CW-1:0] WIN_HI     = CW'(OSR / 2 + WIN);
  localparam logic [GW-1:0] ACQ_LO     = GW'(OSR - ACQ_TOL - 1);
  localparam logic [GW-1:0] ACQ_HI     = GW'(OSR + ACQ_TOL - 1);
  localparam logic [GW-1:0] GAP_MAX    = {GW{1'b1}};

  trk_state_e    st_q, st_d;
  logic [CW-1:0] tick_q, tick_d;
  logic          got_q, got_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          seen_q, seen_d;
  logic          in_win;

  assign in_win = (tick_q >= WIN_LO) && (tick_q <= WIN_HI);

  always_comb begin
    st_d    = st_q;
    tick_d  = tick_q;
    got_d   = got_q;
    gap_d   = gap_q;
    seen_d  = seen_q;
    mid_hit = 1'b0;
    lost    = 1'b0;
    case (st_q)
      TRK_SEARCH: begin
        if (edge_seen) begin
          gap_d = '0;
          if (seen_q && (gap_q >= ACQ_LO) && (gap_q <= ACQ_HI)) begin
            st_d    = TRK_LOCK;
            tick_d  = TICK_AFTER;
            got_d   = 1'b1;
            mid_hit = 1'b1;
          end else begin
            seen_d = 1'b1;
          end
        end else if (gap_q != GAP_MAX) begin
          gap_d = gap_q + GW'(1);
        end
      end
      default: begin
        gap_d  = '0;
        tick_d = (tick_q == TICK_LAST) ? '0 : tick_q + CW'(1);
        if (tick_q == TICK_LAST) got_d = 1'b0;
        if (edge_seen && !got_q && in_win) begin
          mid_hit = 1'b1;
          got_d   = 1'b1;
          tick_d  = TICK_AFTER;
        end else if (!got_q && (tick_q == WIN_HI)) begin
          lost   = 1'b1;
          st_d   = TRK_SEARCH;
          seen_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_SEARCH;
      tick_q <= '0;
      got_q  <= 1'b0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tick_q <= tick_d;
      got_q  <= got_d;
      gap_q  <= gap_d;
      seen_q <= seen_d;
    end
  end

  assign locked = (st_q == TRK_LOCK);

  a_r6_one_hit_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mid_hit |=> !mid_hit);
  a_r7_lost_after_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !edge_seen || !in_win);
endmodule

// File: rtl/mrx_bit_out.sv
module mrx_bit_out (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_hit,
  input  logic mid_rise,
  input  logic pol_invert,
  input  logic lost,
  output logic bit_data,
  output logic bit_valid,
  output logic decode_err
);
  logic data_d, data_q;
  logic valid_q, err_q;
  logic data_en;

  assign data_en = mid_hit;
  assign data_d  = mid_rise ^ pol_invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= 1'b0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= mid_hit;
      err_q   <= lost;
    end
  end

  assign bit_data   = data_q;
  assign bit_valid  = valid_q;
  assign decode_err = err_q;

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |=> !decode_err);
  a_r7_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> !bit_valid);
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int OSR         = 32,
  parameter int WIN         = 4,
  parameter int ACQ_TOL     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slicer_in,
  input  logic pol_invert,
  output logic bit_data,
  output logic bit_valid,
  output logic locked,
  output logic decode_err
);
  logic rst_meta_q, rst_core_n;
  logic lvl, rise, fall, edge_seen;
  logic mid_hit, lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (slicer_in),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign edge_seen = rise | fall;

  mrx_phase_track #(.OSR(OSR), .WIN(WIN), .ACQ_TOL(ACQ_TOL)) u_track (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .edge_seen (edge_seen),
    .mid_hit   (mid_hit),
    .lost      (lost),
    .locked    (locked)
  );

  mrx_bit_out u_out (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mid_hit    (mid_hit),
    .mid_rise   (rise),
    .pol_invert (pol_invert),
    .lost       (lost),
    .bit_data   (bit_data),
    .bit_valid  (bit_valid),
    .decode_err (decode_err)
  );

  a_r3_strobe_needs_lock: assert property (@(posedge clk) disable iff (!rst_core_n)
    bit_valid |-> locked);
  a_r2_lock_with_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(locked) |-> bit_valid);
  a_r7_err_drops_lock: assert property (@(posedge clk) disable iff (!rst_core_n)
    decode_err |-> (!locked && $past(locked)));
  a_r8_quiet_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> (!bit_valid && !decode_err && !locked));
endmodule

// File: tb/manchester_rx_bench.sv
module manchester_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slicer_in = 1'b0;
  logic pol_invert = 1'b0;
  logic bit_data, bit_valid, locked, decode_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  manchester_rx u_manchester_rx (
    .clk(clk), .rst_n(rst_n), .slicer_in(slicer_in), .pol_invert(pol_invert),
    .bit_data(bit_data), .bit_valid(bit_valid), .locked(locked), .decode_err(decode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int r1 = 0, r2 = 0, s1 = 0, s2 = 0, sp = 0;
  int m_lock = 0, m_tick = 0, m_got = 0, m_gap = 0, m_seen = 0;
  int e_valid = 0, e_data = 0, e_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      r1 = 0; r2 = 0;
      s1 = 0; s2 = 0; sp = 0;
      m_lock = 0; m_tick = 0; m_got = 0; m_gap = 0; m_seen = 0;
      e_valid = 0; e_data = 0; e_err = 0;
    end else begin
      if (r2 == 0) begin
        s1 = 0; s2 = 0; sp = 0;
        m_lock = 0; m_tick = 0; m_got = 0; m_gap = 0; m_seen = 0;
        e_valid = 0; e_data = 0; e_err = 0;
      end else begin
        bit edg, up, hit, miss;
        edg = (s2 != sp);
        up = (s2 == 1) && (sp == 0);
        hit = 0; miss = 0;
        if (m_lock == 0) begin
          if (edg) begin
            if (m_seen == 1 && m_gap >= 27 && m_gap <= 35) begin
              m_lock = 1; m_tick = 17; m_got = 1; hit = 1;
            end else m_seen = 1;
            m_gap = 0;
          end else if (m_gap < 127) m_gap = m_gap + 1;
        end else begin
          int old_tick, old_got;
          old_tick = m_tick; old_got = m_got;
          m_gap = 0;
          m_tick = (old_tick + 1) % 32;
          if (old_tick == 31) m_got = 0;
          if (edg && old_got == 0 && old_tick >= 12 && old_tick <= 20) begin
            hit = 1; m_got = 1; m_tick = 17;
          end else if (old_got == 0 && old_tick == 20) begin
            miss = 1; m_lock = 0; m_seen = 0;
          end
        end
        e_valid = hit;
        if (hit) e_data = up ^ pol_invert;
        e_err = miss;
        sp = s2; s2 = s1; s1 = slicer_in;
      end
      r2 = r1; r1 = 1;
    end
  end

  bit got_q[$];
  int err_seen = 0;
  bit lock_seen = 1'b0;

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(bit_valid == e_valid, pol_invert ? "R1/R4 strobe" : "R1/R3 strobe", bit_valid, e_valid);
      if (e_valid)
        chk(bit_data == e_data, pol_invert ? "R4 data" : "R3 data", bit_data, e_data);
      chk(locked == m_lock, "R2 locked", locked, m_lock);
      chk(decode_err == e_err, "R7 decode_err", decode_err, e_err);
      if (bit_valid) got_q.push_back(bit_data);
      if (decode_err) err_seen++;
      if (locked) lock_seen = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    @(negedge clk) slicer_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int h1);
    bit first;
    first = (b == pol_invert);
    slicer_in = first;
    repeat (h1) @(negedge clk);
    slicer_in = !first;
    repeat (32 - h1) @(negedge clk);
  endtask

  task automatic clear_obs();
    got_q.delete();
    err_seen = 0;
    lock_seen = 1'b0;
  endtask

  task automatic check_bits(input bit exp[$], input string req);
    chk(got_q.size() == exp.size(), req, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp[i], req, got_q[i], exp[i]);
  endtask

  initial begin
    bit exp_q[$];
    bit data8 [8];
    int jit [8];
    @(negedge clk);
    @(negedge clk);
    // R8: reset state
    chk(bit_valid == 0 && decode_err == 0 && locked == 0 && bit_data == 0,
        "R8 reset outputs", {bit_valid, decode_err, locked, bit_data}, 0);
    cmp_on = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_valid == 0 && locked == 0, "R8 after release", {bit_valid, locked}, 0);
    idle(40);

    // R9: idle and a run of equal bits never lock
    clear_obs();
    for (int i = 0; i < 10; i++) send_bit(1'b0, 16);
    idle(80);
    chk(lock_seen == 0, "R9 no lock on equal bits", lock_seen, 0);
    chk(got_q.size() == 0, "R9 no strobes", got_q.size(), 0);

    // R2/R3/R6: alternating preamble then data with equal-bit runs, polarity clear
    data8 = '{1, 0, 1, 1, 0, 1, 0, 1};
    clear_obs();
    send_bit(0, 16); send_bit(1, 16); send_bit(0, 16); send_bit(1, 16);
    foreach (data8[i]) send_bit(data8[i], 16);
    idle(80);
    exp_q = '{1, 0, 1};
    foreach (data8[i]) exp_q.push_back(data8[i]);
    chk(lock_seen == 1, "R2 lock acquired", lock_seen, 1);
    check_bits(exp_q, "R3/R6 decoded bits pol0");
    chk(err_seen == 1, "R7 error after message end", err_seen, 1);

    // R4: inverted polarity
    pol_invert = 1'b1;
    idle(40);
    clear_obs();
    send_bit(0, 16); send_bit(1, 16); send_bit(0, 16); send_bit(1, 16);
    data8 = '{0, 0, 1, 1, 1, 0, 0, 1};
    foreach (data8[i]) send_bit(data8[i], 16);
    idle(80);
    exp_q = '{1, 0, 1};
    foreach (data8[i]) exp_q.push_back(data8[i]);
    check_bits(exp_q, "R4 decoded bits pol1");
    chk(err_seen == 1, "R7 error after message end pol1", err_seen, 1);
    pol_invert = 1'b0;
    idle(40);

    // R5: drifting mid-bit edges
    clear_obs();
    send_bit(0, 16); send_bit(1, 16); send_bit(0, 16); send_bit(1, 16);
    data8 = '{0, 1, 1, 0, 1, 0, 0, 1};
    jit = '{18, 20, 17, 14, 12, 15, 16, 19};
    foreach (data8[i]) send_bit(data8[i], jit[i]);
    idle(80);
    exp_q = '{1, 0, 1};
    foreach (data8[i]) exp_q.push_back(data8[i]);
    check_bits(exp_q, "R5 drifting edges");

    // R7: mid-bit edge 7 ticks late
    clear_obs();
    send_bit(0, 16); send_bit(1, 16); send_bit(0, 16); send_bit(1, 16);
    send_bit(1, 16); send_bit(0, 16); send_bit(1, 23);
    idle(40);
    exp_q = '{1, 0, 1, 1, 0};
    check_bits(exp_q, "R7 bits before late edge");
    chk(err_seen == 1, "R7 late edge error", err_seen, 1);
    chk(locked == 0, "R7 unlocked after error", locked, 0);

    // R2: relock after error
    clear_obs();
    send_bit(0, 16); send_bit(1, 16); send_bit(1, 16);
    idle(80);
    exp_q = '{1, 1};
    check_bits(exp_q, "R2 relock");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule